// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns one parallel character into a serial frame on a single output line that rests at logic high. A host places a character on the data input, sets the frame format (data length, parity, stop count) and a bit-period divider, and then raises a send request. The transmitter answers with a busy flag. It shifts the frame out at the programmed bit rate and drops busy when the final stop bit has ended.

The host handshake has four phases. The host holds the request until busy falls, and then withdraws it. A request that stays high after busy falls starts nothing. The request has to be seen low while the block is idle, and then high again, before the next frame begins. The character, the format and the divider are captured on the cycle the frame starts, so the host may change them freely while a frame is on the line.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset and whenever busy is low, txd is 1. Every frame begins with one start bit at 0.
- R2: cfg_len selects the data length: code 0 gives 5 bits, code 1 gives 7 bits, and codes 2 and 3 give 8 bits. Data bits are sent least significant bit first, taken from tx_data[0] upward.
- R3: When cfg_par_en is 1, one parity bit follows the data bits. It is computed over the configured data bits only. cfg_par_odd=0 makes the count of ones in data plus parity even, and cfg_par_odd=1 makes it odd. When cfg_par_en is 0, no parity bit is sent.
- R4: The frame ends with stop bits at 1: one stop bit when cfg_two_stop is 0, and two when it is 1.
- R5: Every bit of the frame lasts exactly cfg_div+1 clock cycles. cfg_div=0 gives one cycle per bit.
- R6: Busy rises on the clock edge that samples send_req high while the block is idle and armed. The start bit appears in the same cycle. Busy stays high for exactly N*(cfg_div+1) cycles, where N = 1 + data bits + parity bit + stop bits.
- R7: A new frame starts only after send_req has been sampled low while busy is low, and then sampled high. A request held high after busy falls, or held high through the release of reset, starts no frame.
- R8: Changes to tx_data, cfg_len, cfg_par_en, cfg_par_odd, cfg_two_stop or cfg_div after a frame has started do not alter that frame.
- R9: While a frame is in progress, txd changes only at bit boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| send_req | input | 1 | Host send request, four-phase handshake |
| tx_data | input | 8 | Character to send, bit 0 sent first |
| cfg_len | input | 2 | Data length code (0:5, 1:7, 2/3:8) |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_div | input | 16 | Bit period minus one, in clock cycles |
| busy | output | 1 | Frame in progress |
| txd | output | 1 | Serial line, idle high |

## Verification
Each frame is compared cycle by cycle against a bit sequence that the bench builds itself. Random characters, lengths, parity modes, stop counts and short dividers are mixed with directed frames: the one-cycle bit, all-ones and all-zeros data with both parity senses, and the 5-bit length with upper data bits set to catch parity computed over the wrong width. Half of the frames change every data and configuration input right after the start, which separates a design that captures its inputs at the start from one that reads them live. After every frame and across the release of reset the request is held high, which separates a true four-phase handshake from a level-triggered start.

// File: rtl/uft_pkg.sv
package uft_pkg;
  localparam int UFT_DATA_W  = 8;
  localparam int UFT_FRAME_W = 1 + UFT_DATA_W + 1 + 2;

  function automatic int uft_data_bits(input logic [1:0] len_code);
    case (len_code)
      2'd0:    return 5;
      2'd1:    return 7;
      default: return 8;
    endcase
  endfunction

  function automatic logic uft_parity(input logic [UFT_DATA_W-1:0] d,
                                      input logic [1:0] len_code,
                                      input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < UFT_DATA_W; i++)
      if (i < uft_data_bits(len_code)) p = p ^ d[i];
    return p;
  endfunction

  function automatic logic [3:0] uft_frame_len(input logic [1:0] len_code,
                                               input logic par_en,
                                               input logic two_stop);
    return 4'(1 + uft_data_bits(len_code) + int'(par_en) + 1 + int'(two_stop));
  endfunction

  // Start bit at index 0; stop bits and unused tail are ones.
  function automatic logic [UFT_FRAME_W-1:0] uft_build_frame(
      input logic [UFT_DATA_W-1:0] d, input logic [1:0] len_code,
      input logic par_en, input logic odd);
    logic [UFT_FRAME_W-1:0] f;
    int nd;
    nd = uft_data_bits(len_code);
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < UFT_DATA_W; i++)
      if (i < nd) f[1+i] = d[i];
    if (par_en) f[1+nd] = uft_parity(d, len_code, odd);
    return f;
  endfunction
endpackage

// File: rtl/uft_baud.sv
module uft_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] per_q;

  assign tick = run && (cnt_q == per_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      per_q <= div_in;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uft_handshake.sv
module uft_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic send_req,
  input  logic busy,
  output logic start,
  output logic armed
);
  logic armed_q;

  assign armed = armed_q;
  assign start = armed_q && send_req && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  armed_q <= 1'b0;
    else if (start)              armed_q <= 1'b0;
    else if (!send_req && !busy) armed_q <= 1'b1;
  end
endmodule

// File: rtl/uft_frame.sv
module uft_frame
  import uft_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  tick,
  input  logic [UFT_DATA_W-1:0] data,
  input  logic [1:0]            len_code,
  input  logic                  par_en,
  input  logic                  par_odd,
  input  logic                  two_stop,
  output logic                  busy,
  output logic                  txd,
  output logic                  stop_phase
);
  logic [UFT_FRAME_W-1:0] sr_q;
  logic [3:0]             idx_q;
  logic [3:0]             nbits_q;
  logic [3:0]             stop_at_q;
  logic                   busy_q;
  logic                   last_bit;

  assign busy       = busy_q;
  assign txd        = sr_q[0];
  assign last_bit   = (idx_q == nbits_q - 4'd1);
  assign stop_phase = busy_q && (idx_q >= stop_at_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q      <= '1;
      idx_q     <= '0;
      nbits_q   <= '0;
      stop_at_q <= '0;
      busy_q    <= 1'b0;
    end else if (start) begin
      sr_q      <= uft_build_frame(data, len_code, par_en, par_odd);
      idx_q     <= '0;
      nbits_q   <= uft_frame_len(len_code, par_en, two_stop);
      stop_at_q <= uft_frame_len(len_code, par_en, 1'b0) - 4'd1;
      busy_q    <= 1'b1;
    end else if (tick) begin
      sr_q  <= {1'b1, sr_q[UFT_FRAME_W-1:1]};
      idx_q <= idx_q + 4'd1;
      if (last_bit) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             send_req,
  input  logic [7:0]       tx_data,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_two_stop,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             busy,
  output logic             txd
);
  logic frame_start;
  logic armed;
  logic bit_tick;
  logic stop_phase;

  uft_handshake hs_i (
    .clk(clk), .rst_n(rst_n), .send_req(send_req), .busy(busy),
    .start(frame_start), .armed(armed)
  );

  uft_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .div_in(cfg_div),
    .run(busy), .tick(bit_tick)
  );

  uft_frame frame_i (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .tick(bit_tick),
    .data(tx_data), .len_code(cfg_len), .par_en(cfg_par_en),
    .par_odd(cfg_par_odd), .two_stop(cfg_two_stop),
    .busy(busy), .txd(txd), .stop_phase(stop_phase)
  );
endmodule

// File: rtl/uft_checks.sv
module uft_checks (
  input logic clk,
  input logic rst_n,
  input logic send_req,
  input logic busy,
  input logic txd,
  input logic tick,
  input logic armed,
  input logic stop_phase
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  assert_stop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_phase |-> txd);
  assert_busy_on_send_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(send_req));
  assert_armed_before_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> !busy);
  assert_line_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd));
endmodule

bind uart_frame_tx uft_checks chk_i (
  .clk(clk), .rst_n(rst_n), .send_req(send_req), .busy(busy), .txd(txd),
  .tick(bit_tick), .armed(armed), .stop_phase(stop_phase)
);

// File: tb/uart_frame_tx_tb_top.sv
`timescale 1ns/1ps
module uart_frame_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        send_req = 1'b0;
  logic [7:0]  tx_data = '0;
  logic [1:0]  cfg_len = '0;
  logic        cfg_par_en = 1'b0;
  logic        cfg_par_odd = 1'b0;
  logic        cfg_two_stop = 1'b0;
  logic [15:0] cfg_div = '0;
  logic        busy;
  logic        txd;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .send_req(send_req), .tx_data(tx_data),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_div(cfg_div), .busy(busy), .txd(txd)
  );

  function automatic int n_data(input logic [1:0] code);
    return (code == 2'd0) ? 5 : (code == 2'd1) ? 7 : 8;
  endfunction

  function automatic int n_total(input logic [1:0] code, input bit pe, input bit ts);
    return 2 + n_data(code) + (pe ? 1 : 0) + (ts ? 1 : 0);
  endfunction

  // Expected line level for bit position k of the frame.
  function automatic logic exp_bit(input int k, input logic [7:0] d,
                                   input logic [1:0] code, input bit pe, input bit po);
    int nd;
    logic [7:0] m;
    nd = n_data(code);
    m = 8'((9'd1 << nd) - 9'd1);
    if (k == 0) return 1'b0;
    if (k <= nd) return d[k-1];
    if (pe && k == nd + 1) return (^(d & m)) ? ~po : po;
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [1:0] code, input bit pe,
                           input bit po, input bit ts, input logic [15:0] dv,
                           input bit scramble);
    int nb, per, first_bad, got;
    logic e;
    nb = n_total(code, pe, ts);
    per = int'(dv) + 1;
    first_bad = -1;
    got = 0;
    @(negedge clk);
    tx_data = d; cfg_len = code; cfg_par_en = pe; cfg_par_odd = po;
    cfg_two_stop = ts; cfg_div = dv; send_req = 1'b1;
    @(negedge clk);
    check(busy === 1'b1 && txd === 1'b0, "R1/R6 start", {busy, txd}, 2);
    for (int c = 0; c < nb * per; c++) begin
      e = exp_bit(c / per, d, code, pe, po);
      if ((txd !== e || busy !== 1'b1) && first_bad < 0) begin
        first_bad = c; got = {busy, txd};
      end
      if (scramble && c == 0) begin
        tx_data = 8'($urandom); cfg_len = 2'($urandom); cfg_par_en = 1'($urandom);
        cfg_par_odd = 1'($urandom); cfg_two_stop = 1'($urandom);
        cfg_div = 16'($urandom_range(0, 6));
      end
      @(negedge clk);
    end
    if (first_bad >= 0)
      check(1'b0, scramble ? "R8 frame after input change" : "R2/R3/R4/R5 frame bits",
            got, {1'b1, exp_bit(first_bad / per, d, code, pe, po)});
    else
      check(1'b1, "R2 frame", 0, 0);
    check(busy === 1'b0 && txd === 1'b1, "R6 busy end", {busy, txd}, 1);
    got = 0;
    for (int c = 0; c < 4; c++) begin
      if (busy !== 1'b0) got = 1;
      @(negedge clk);
    end
    check(got == 0, "R7 held request restarted", got, 0);
    send_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    send_req = 1'b1;
    #23;
    check(busy === 1'b0 && txd === 1'b1, "R1 reset state", {busy, txd}, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(busy === 1'b0 && txd === 1'b1, "R7 request held over reset", {busy, txd}, 1);
    send_req = 1'b0;
    repeat (2) @(negedge clk);

    run_frame(8'hFF, 2'd2, 1'b1, 1'b0, 1'b0, 16'd0, 1'b0); // R5 one-cycle bit, R3 even
    run_frame(8'hFF, 2'd2, 1'b1, 1'b1, 1'b1, 16'd2, 1'b0); // R3 odd, R4 two stops
    run_frame(8'h00, 2'd0, 1'b1, 1'b1, 1'b1, 16'd1, 1'b0); // R2 5-bit, R3 odd on zeros
    run_frame(8'hE1, 2'd0, 1'b1, 1'b0, 1'b0, 16'd3, 1'b0); // R3 upper bits ignored
    run_frame(8'h57, 2'd1, 1'b0, 1'b0, 1'b0, 16'd4, 1'b1); // R2 7-bit, R8
    run_frame(8'hA5, 2'd3, 1'b0, 1'b0, 1'b1, 16'd0, 1'b1); // R8 with one-cycle bits
    for (int n = 0; n < 40; n++)
      run_frame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                16'($urandom_range(0, 5)), 1'(n % 2));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule